// File: doc/BRIEF.md
# Programmable Comparison-Clock Divider with Monitor Output

This block divides a reference clock down to a comparison rate for a phase detector. A four-bit ratio code picks the division ratio. Half of the codes give the binary ratios 2 through 256. Most of the other half give three times a power of two, from 6 up to 384. One code is forbidden. The divider produces a one-cycle comparison enable once per period. It also produces an internal comparison clock, which is high for the first half of each period.

A monitor output lets a second circuit borrow either the raw reference or the comparison clock. It can also be parked at a steady high level. The ratio code, the monitor enable and the monitor select are captured together on a load strobe. After reset the monitor enable and select both read as 1, so the comparison clock appears at the monitor output until software changes them.

A new ratio never cuts a running period short. A loaded code waits in a pending register and replaces the active code only when the current period ends. If the forbidden code is loaded, the pending ratio is left alone and an error flag rises. The next load of a valid code clears the flag.

Top module: `cmpclk_refdiv`

## Requirements
- R1: Ratio codes 4'b0000 through 4'b0111 give periods of 2, 4, 8, 16, 32, 64, 128 and 256 reference cycles, in that code order. The period is measured between successive `cmp_en` pulses.
- R2: Ratio codes 4'b1001 through 4'b1111 give periods of 6, 12, 24, 48, 96, 192 and 384 reference cycles, in that code order.
- R3: Loading code 4'b1000 leaves the ratio in use unchanged and sets `code_err` on the clock edge that captures the load. A later load of any other code clears `code_err`.
- R4: A code loaded partway through a period does not change the length of that period. It takes effect starting with the next period.
- R5: `cmp_en` is high for exactly one reference cycle per period, in the last cycle of the period. After reset is released, the first pulse comes on the second rising edge.
- R6: The comparison clock is high for the first half of each period and low for the second half. The first half starts on the edge after a `cmp_en` pulse. It is observed at `mon_out` with enable=1 and select=1.
- R7: With the captured monitor enable at 1 and select at 0, `mon_out` follows `ref_clk`.
- R8: With the captured monitor enable at 0, `mon_out` stays high whatever the select value and the divider phase.
- R9: Reset sets these values:
  - ratio code 4'b0000 (period 2);
  - monitor enable 1;
  - monitor select 1;
  - `code_err` 0;
  - divider count 0, so `mon_out` starts high and `cmp_en` starts low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Captures ratio_code, mon_en and mon_sel on this edge |
| ratio_code | input | 4 | Ratio code: bit 3 picks the times-three series, bits 2:0 the power of two |
| mon_en | input | 1 | Monitor enable value to capture (0 holds mon_out high) |
| mon_sel | input | 1 | Monitor select value to capture (0 reference, 1 comparison clock) |
| cmp_en | output | 1 | One-cycle pulse in the last cycle of each comparison period |
| mon_out | output | 1 | Monitor output: reference, comparison clock or steady high |
| code_err | output | 1 | Set when the forbidden code is loaded, cleared by a valid load |

## Verification
Every legal code is loaded, and the bench measures the spacing of `cmp_en` pulses against the expected ratio. A table indexed in the wrong order, or a shift off by one, shows up as a wrong period. The forbidden code is loaded while a known ratio is running. A design that accepted it would shift the period or fail to raise `code_err`. A ratio change is issued in mid-period and the cycles to the next pulse are counted. A design that applies the code at once would end the running period early. The monitor is checked in all three modes at both clock phases, including the duty pattern of the comparison clock. A swapped select, or a disabled output that floats low, therefore fails.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   // width of the ratio code and of the largest ratio (384 needs 9 bits)
   localparam int CODE_W  = 4;
   localparam int RATIO_W = 9;
   localparam logic [CODE_W-1:0] FORBIDDEN_CODE = 4'b1000;

   // bit 3 clear: 2 << k ; bit 3 set: 3 << k (k = bits 2:0)
   function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
      logic [RATIO_W-1:0] base;
      logic [3:0]         shift;
      base  = code[3] ? RATIO_W'(3) : RATIO_W'(1);
      shift = code[3] ? {1'b0, code[2:0]} : ({1'b0, code[2:0]} + 4'd1);
      return base << shift;
   endfunction

endpackage

// File: rtl/refdiv_cfg_reg.sv
module refdiv_cfg_reg
   import refdiv_pkg::*;
#(
   parameter int                CW         = CODE_W,
   parameter logic [CW-1:0]     RESET_CODE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] code_in,
   input  logic          en_in,
   input  logic          sel_in,
   output logic [CW-1:0] pend_code,
   output logic          en_q,
   output logic          sel_q,
   output logic          err_q
);

   generate
      if (CW != CODE_W) begin : g_bad_cw
         $error("refdiv_cfg_reg: code width must equal the package code width");
      end
      if (RESET_CODE == FORBIDDEN_CODE) begin : g_bad_reset
         $error("refdiv_cfg_reg: reset code may not be the forbidden code");
      end
   endgenerate

   logic bad_code;
   assign bad_code = (code_in == FORBIDDEN_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_code <= RESET_CODE;
         en_q      <= 1'b1;
         sel_q     <= 1'b1;
         err_q     <= 1'b0;
      end else if (load) begin
         en_q  <= en_in;
         sel_q <= sel_in;
         if (bad_code) begin
            err_q <= 1'b1;
         end else begin
            pend_code <= code_in;
            err_q     <= 1'b0;
         end
      end
   end

   // forbidden load keeps the pending ratio and flags the error
   assert_bad_code_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && bad_code) |=> (err_q && $stable(pend_code)));

   // a legal load clears the error flag
   assert_good_code_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !bad_code) |=> !err_q);

   // monitor settings move only on a load
   assert_mon_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(en_q) && $stable(sel_q)));

endmodule

// File: rtl/refdiv_period_ctr.sv
module refdiv_period_ctr
   import refdiv_pkg::*;
#(
   parameter int            CW          = CODE_W,
   parameter int            CNT_W       = RATIO_W,
   parameter logic [CW-1:0] RESET_CODE  = '0,
   parameter bit            REG_CMP_CLK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] pend_code,
   output logic          cmp_en,
   output logic          cmp_clk
);

   generate
      if (CNT_W < RATIO_W) begin : g_bad_cnt
         $error("refdiv_period_ctr: counter too narrow for the largest ratio");
      end
   endgenerate

   logic [CW-1:0]    act_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ratio;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] half;
   logic             wrap;

   assign ratio  = CNT_W'(ratio_of(act_q));
   assign term   = ratio - CNT_W'(1);
   assign half   = ratio >> 1;
   assign wrap   = (cnt_q == term);
   assign cmp_en = wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= RESET_CODE;
      end else if (wrap) begin
         cnt_q <= '0;
         act_q <= pend_code;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   generate
      if (REG_CMP_CLK) begin : g_cmp_reg
         logic cmp_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cmp_q <= 1'b1;
            end else if (wrap) begin
               cmp_q <= 1'b1;
            end else begin
               cmp_q <= ((cnt_q + CNT_W'(1)) < half);
            end
         end
         assign cmp_clk = cmp_q;
      end else begin : g_cmp_comb
         assign cmp_clk = (cnt_q < half);
      end
   endgenerate

   // the enable is a single-cycle pulse (every ratio is at least 2)
   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en |=> !cmp_en);

   // the count never passes the end of the period
   assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= term);

   // the forbidden code never becomes the active ratio
   assert_no_forbidden_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act_q != FORBIDDEN_CODE);

   // the active ratio changes only at a period boundary
   assert_switch_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q != $past(act_q)) |-> $past(wrap));

   // each period opens with the comparison clock high
   assert_first_half_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en |=> cmp_clk);

endmodule

// File: rtl/refdiv_mon_mux.sv
module refdiv_mon_mux #(
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic ref_clk,
   input  logic cmp_clk,
   input  logic en,
   input  logic sel,
   output logic mon_out
);

   always_comb begin
      if (!en) begin
         mon_out = IDLE_LEVEL;
      end else if (sel) begin
         mon_out = cmp_clk;
      end else begin
         mon_out = ref_clk;
      end
   end

endmodule

// File: rtl/cmpclk_refdiv.sv
module cmpclk_refdiv
   import refdiv_pkg::*;
#(
   parameter int                CNT_W       = RATIO_W,
   parameter logic [CODE_W-1:0] RESET_CODE  = 4'b0000,
   parameter bit                REG_CMP_CLK = 1'b1
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [CODE_W-1:0] ratio_code,
   input  logic              mon_en,
   input  logic              mon_sel,
   output logic              cmp_en,
   output logic              mon_out,
   output logic              code_err
);

   logic [CODE_W-1:0] pend_code;
   logic              en_q;
   logic              sel_q;
   logic              cmp_clk;

   refdiv_cfg_reg #(
      .CW         (CODE_W),
      .RESET_CODE (RESET_CODE)
   ) u_cfg (
      .clk       (ref_clk),
      .rst_n     (rst_n),
      .load      (cfg_load),
      .code_in   (ratio_code),
      .en_in     (mon_en),
      .sel_in    (mon_sel),
      .pend_code (pend_code),
      .en_q      (en_q),
      .sel_q     (sel_q),
      .err_q     (code_err)
   );

   refdiv_period_ctr #(
      .CW          (CODE_W),
      .CNT_W       (CNT_W),
      .RESET_CODE  (RESET_CODE),
      .REG_CMP_CLK (REG_CMP_CLK)
   ) u_ctr (
      .clk       (ref_clk),
      .rst_n     (rst_n),
      .pend_code (pend_code),
      .cmp_en    (cmp_en),
      .cmp_clk   (cmp_clk)
   );

   refdiv_mon_mux #(
      .IDLE_LEVEL (1'b1)
   ) u_mon (
      .ref_clk (ref_clk),
      .cmp_clk (cmp_clk),
      .en      (en_q),
      .sel     (sel_q),
      .mon_out (mon_out)
   );

   // disabled monitor is parked high at both clock phases
   assert_mon_parked_high_R8: assert property (@(negedge ref_clk) disable iff (!rst_n)
      !en_q |-> mon_out);

endmodule

// File: tb/cmpclk_refdiv_test.sv
module cmpclk_refdiv_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_load = 1'b0;
   logic [3:0] ratio_code = 4'b0000;
   logic       mon_en = 1'b1;
   logic       mon_sel = 1'b1;
   logic       cmp_en;
   logic       mon_out;
   logic       code_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cmpclk_refdiv uut (
      .ref_clk    (clk),
      .rst_n      (rst_n),
      .cfg_load   (cfg_load),
      .ratio_code (ratio_code),
      .mon_en     (mon_en),
      .mon_sel    (mon_sel),
      .cmp_en     (cmp_en),
      .mon_out    (mon_out),
      .code_err   (code_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_ratio(input logic [3:0] c);
      int p;
      p = c[3] ? 3 : 2;
      for (int i = 0; i < c[2:0]; i++) p = p * 2;
      if (c[3]) p = p * 1; // 3 << k for the times-three series
      return p;
   endfunction

   task automatic load_cfg(input logic [3:0] c, input logic en, input logic sel);
      ratio_code = c;
      mon_en     = en;
      mon_sel    = sel;
      cfg_load   = 1'b1;
      @(negedge clk);
      cfg_load   = 1'b0;
   endtask

   // advance to the next negedge where cmp_en is high
   task automatic wait_pulse();
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cmp_en && n < 1000);
      if (!cmp_en) chk("R5 pulse timeout", 0, 1);
   endtask

   // from a pulse, count cycles to the next pulse
   task automatic measure(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cmp_en && n < 1000);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R9 mon_out high at reset", mon_out, 1);
      chk("R9 cmp_en low at reset", cmp_en, 0);
      chk("R9 code_err clear at reset", code_err, 0);
      @(negedge clk);
      chk("R5 first pulse on second edge", cmp_en, 1);
      chk("R9 monitor shows comparison clock low half", mon_out, 0);
      begin
         int n;
         measure(n);
         chk("R9 reset ratio period 2", n, 2);
      end
   endtask

   task automatic t_series(input bit triple);
      for (int k = 0; k < 8; k++) begin
         logic [3:0] c;
         int n;
         if (triple && k == 0) continue;
         c = {triple, 3'(k)};
         load_cfg(c, 1'b1, 1'b1);
         wait_pulse();
         measure(n);
         chk(triple ? "R2 times-three period" : "R1 binary period", n,
             triple ? 3 * (1 << k) : exp_ratio(c));
      end
   endtask

   task automatic t_forbidden();
      int n;
      load_cfg(4'b0010, 1'b1, 1'b1);
      wait_pulse();
      load_cfg(4'b1000, 1'b1, 1'b1);
      chk("R3 code_err raised", code_err, 1);
      wait_pulse();
      measure(n);
      chk("R3 ratio kept after forbidden code", n, 8);
      load_cfg(4'b1001, 1'b1, 1'b1);
      chk("R3 code_err cleared by valid load", code_err, 0);
      wait_pulse();
      measure(n);
      chk("R3 valid code after error applied", n, 6);
   endtask

   task automatic t_switch();
      int n;
      load_cfg(4'b0011, 1'b1, 1'b1);
      wait_pulse();
      measure(n);
      chk("R4 setup period 16", n, 16);
      repeat (3) @(negedge clk);
      ratio_code = 4'b0001;
      cfg_load   = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         cfg_load = 1'b0;
         n++;
      end while (!cmp_en && n < 1000);
      chk("R4 running period not cut short", n, 13);
      measure(n);
      chk("R4 new ratio from next period", n, 4);
   endtask

   task automatic t_halves();
      load_cfg(4'b0010, 1'b1, 1'b1);
      wait_pulse();
      wait_pulse();
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R6 comparison clock duty", mon_out, (i < 4) ? 1 : 0);
      end
   endtask

   task automatic t_mon_ref();
      load_cfg(4'b0010, 1'b1, 1'b0);
      repeat (2) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         #5;
         chk("R7 monitor follows reference high", mon_out, 1);
         @(negedge clk);
         #5;
         chk("R7 monitor follows reference low", mon_out, 0);
      end
   endtask

   task automatic t_mon_off();
      load_cfg(4'b0010, 1'b0, 1'b1);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R8 disabled monitor high (select 1)", mon_out, 1);
      end
      load_cfg(4'b0010, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk);
         #5;
         chk("R8 disabled monitor high (select 0, clk high)", mon_out, 1);
         @(negedge clk);
         #5;
         chk("R8 disabled monitor high (select 0, clk low)", mon_out, 1);
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_series(1'b0);
      t_series(1'b1);
      t_forbidden();
      t_switch();
      t_halves();
      t_mon_ref();
      t_mon_off();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule